// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block produces the line and frame timing for a raster display from a set of programmable counts. A horizontal counter steps once per clock across a line and a vertical counter steps once per line across a frame. Blanking, sync and a vertical interrupt window are decoded by comparing those counters with start and end counts held in a small register file. A write port loads the file one 12-bit word at a time.

A status word in the file decides which four timing signals appear on the four output pins, the active level of each pin, and whether the counters run at all. Composite sync is formed here as the plain OR of horizontal and vertical sync. Equalization and serration shaping, and any pixel path, live elsewhere. Their registers are stored but have no effect on the pins.

Top module: `raster_sync_gen`

## Requirements
- R1: On reset both counters are 0 and every register is 0, except the status word. The status word resets to 0x400 (counting on) when CLK_ON_AT_RESET is 1, which is the default, and to 0 otherwise. With default settings the pins read 4'b0011 (pin 0 is the LSB).
- R2: A write with wrEn high at a rising edge stores wrData in register wrAddr. The new value governs the counters and the pins from that edge onward. A compare made at the same edge still uses the old value.
- R3: While counting is on, the horizontal counter adds one each clock. In the clock where it equals register 4 minus one (modulo 4096), it wraps to 0 and the vertical counter advances.
- R4: At a horizontal wrap where the vertical counter equals register 8 minus one, the vertical counter wraps to 0.
- R5: A window is active when its counter is at or above its start count and below its end count. Horizontal blank spans 0 up to register 3, and vertical blank spans 0 up to register 7.
- R6: Horizontal sync spans register 1 up to register 2. Vertical sync spans register 5 up to register 6, counted in lines.
- R7: The vertical interrupt spans register 13 up to register 14, counted in lines.
- R8: Status bits 2:0 select the pins, listed as pin0/pin1/pin2/pin3. 000: cblank/csync/hgate/vgate. 001: vblank/csync/hblank/vgate. 010: cblank/vsync/hgate/hsync. 011 and 111: vblank/vsync/hblank/hsync. 100: cblank/csync/cursor/vint. 101: vblank/csync/hblank/vint. 110: cblank/vsync/cursor/hsync.
- R9: Status bit 5+n sets the level of pin n. A 1 drives the signal as is (active high). A 0 drives its inverse (active low).
- R10: While status bit 10 is 0, both counters hold and the pins do not change unless a register is written.
- R11: Composite blank is hblank OR vblank. Composite sync is hsync OR vsync. Each gate is the inverse of its blank. The cursor signal is always inactive.
- R12: Status bits 3, 4, 9 and 11, and registers 9 to 12, have no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register index, 0 to 14 |
| wrData | input | 12 | Value to store |
| outPin | output | 4 | Selected timing signals after level adjustment |

## Verification
Two functions can act in the same cycle: a register write and the counter wrap that depends on that register. The bench waits until the horizontal counter sits one step short of its terminal count. It then writes a new line length so that the write lands on the wrap edge itself. The reference model applies the old length at that edge and the new one afterwards, and every pin is compared against it in the following cycles. A write that clears the counting bit on a wrap edge is handled the same way.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  localparam int DATA_W   = 12;
  localparam int ADDR_W   = 4;
  localparam int NUM_REGS = 15;
  localparam int NUM_PINS = 4;

  // register indices that the decode depends on
  localparam int IDX_STATUS    = 0;
  localparam int IDX_H_FP      = 1;
  localparam int IDX_H_SYNCEND = 2;
  localparam int IDX_H_BLANK   = 3;
  localparam int IDX_H_TOTAL   = 4;
  localparam int IDX_V_FP      = 5;
  localparam int IDX_V_SYNCEND = 6;
  localparam int IDX_V_BLANK   = 7;
  localparam int IDX_V_TOTAL   = 8;
  localparam int IDX_VINT_ON   = 13;
  localparam int IDX_VINT_OFF  = 14;

  // status word fields
  localparam int ST_SEL_LSB = 0;
  localparam int ST_POL_LSB = 5;
  localparam int ST_CLK_EN  = 10;

  // decoded windows
  localparam int WIN_HBLANK = 0;
  localparam int WIN_HSYNC  = 1;
  localparam int WIN_VBLANK = 2;
  localparam int WIN_VSYNC  = 3;
  localparam int WIN_VINT   = 4;
  localparam int NUM_WIN    = 5;

  typedef struct packed {
    logic hStep;
    logic hWrap;
    logic vStep;
    logic vWrap;
  } cnt_strobe_t;

endpackage

// File: rtl/rsg_regfile.sv
module rsg_regfile #(
  parameter int DATA_W   = 12,
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 15,
  parameter logic [DATA_W-1:0] STATUS_RST = '0
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                wrAddr,
  input  logic [DATA_W-1:0]                wrData,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regQ
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL = (i == 0) ? STATUS_RST : '0;
    logic [DATA_W-1:0] q;
    logic hit;

    assign hit = wrEn && (wrAddr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        q <= RST_VAL;
      end else if (hit) begin
        q <= wrData;
      end
    end

    assign regQ[i] = q;
  end

endmodule

// File: rtl/rsg_window.sv
module rsg_window #(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] cnt,
  input  logic [DATA_W-1:0] startCnt,
  input  logic [DATA_W-1:0] endCnt,
  output logic              active
);

  logic atOrAfterStart;
  logic beforeEnd;

  assign atOrAfterStart = (cnt >= startCnt);
  assign beforeEnd      = (cnt < endCnt);
  assign active         = atOrAfterStart && beforeEnd;

endmodule

// File: rtl/rsg_ctrl.sv
module rsg_ctrl
  import rsg_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] hCount,
  input  logic [DATA_W-1:0] vCount,
  input  logic [DATA_W-1:0] hTotal,
  input  logic [DATA_W-1:0] vTotal,
  input  logic              clkEn,
  output cnt_strobe_t       strobe
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] hLastVal;
  logic [DATA_W-1:0] vLastVal;
  logic hLast;
  logic vLast;

  // terminal counts wrap modulo 2**DATA_W, so a total of 0 gives the full range
  assign hLastVal = hTotal - ONE;
  assign vLastVal = vTotal - ONE;
  assign hLast    = (hCount == hLastVal);
  assign vLast    = (vCount == vLastVal);

  always_comb begin
    strobe.hStep = clkEn && !hLast;
    strobe.hWrap = clkEn && hLast;
    strobe.vStep = strobe.hWrap && !vLast;
    strobe.vWrap = strobe.hWrap && vLast;
  end

endmodule

// File: rtl/rsg_datapath.sv
module rsg_datapath
  import rsg_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int NUM_WIN  = 5,
  parameter int NUM_PINS = 4,
  parameter logic [NUM_WIN-1:0] WIN_IS_V = 5'b11100
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  cnt_strobe_t                     strobe,
  input  logic [NUM_WIN-1:0][DATA_W-1:0]  winStart,
  input  logic [NUM_WIN-1:0][DATA_W-1:0]  winEnd,
  input  logic [2:0]                      outSel,
  input  logic [NUM_PINS-1:0]             pinPol,
  output logic [DATA_W-1:0]               hCount,
  output logic [DATA_W-1:0]               vCount,
  output logic [NUM_PINS-1:0]             outPin
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [NUM_WIN-1:0] winAct;
  logic hBlank, hSync, vBlank, vSync, vInt;
  logic cBlank, cSync, hGate, vGate, cursor;
  logic [NUM_PINS-1:0] pinSig;

  // counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCount <= '0;
    end else if (strobe.hWrap) begin
      hCount <= '0;
    end else if (strobe.hStep) begin
      hCount <= hCount + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vCount <= '0;
    end else if (strobe.vWrap) begin
      vCount <= '0;
    end else if (strobe.vStep) begin
      vCount <= vCount + ONE;
    end
  end

  // window decode, one comparator pair per window
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [DATA_W-1:0] cntSel;
    if (WIN_IS_V[w]) begin : g_v
      assign cntSel = vCount;
    end else begin : g_h
      assign cntSel = hCount;
    end
    rsg_window #(.DATA_W(DATA_W)) i_win (
      .cnt      (cntSel),
      .startCnt (winStart[w]),
      .endCnt   (winEnd[w]),
      .active   (winAct[w])
    );
  end

  assign hBlank = winAct[WIN_HBLANK];
  assign hSync  = winAct[WIN_HSYNC];
  assign vBlank = winAct[WIN_VBLANK];
  assign vSync  = winAct[WIN_VSYNC];
  assign vInt   = winAct[WIN_VINT];

  assign cBlank = hBlank | vBlank;
  assign cSync  = hSync | vSync;
  assign hGate  = ~hBlank;
  assign vGate  = ~vBlank;
  assign cursor = 1'b0;

  // pin selection, listed pin3..pin0
  always_comb begin
    unique case (outSel)
      3'b000:  pinSig = {vGate,  hGate,  cSync, cBlank};
      3'b001:  pinSig = {vGate,  hBlank, cSync, vBlank};
      3'b010:  pinSig = {hSync,  hGate,  vSync, cBlank};
      3'b100:  pinSig = {vInt,   cursor, cSync, cBlank};
      3'b101:  pinSig = {vInt,   hBlank, cSync, vBlank};
      3'b110:  pinSig = {hSync,  cursor, vSync, cBlank};
      default: pinSig = {hSync,  hBlank, vSync, vBlank};
    endcase
  end

  // per-pin active level
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pol
    assign outPin[p] = pinPol[p] ? pinSig[p] : ~pinSig[p];
  end

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import rsg_pkg::*;
#(
  parameter int DATA_W          = rsg_pkg::DATA_W,
  parameter int ADDR_W          = rsg_pkg::ADDR_W,
  parameter int NUM_REGS        = rsg_pkg::NUM_REGS,
  parameter int NUM_PINS        = rsg_pkg::NUM_PINS,
  parameter bit CLK_ON_AT_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [11:0]       wrData,
  output logic [3:0]        outPin
);

  localparam logic [DATA_W-1:0] STATUS_RST =
    CLK_ON_AT_RESET ? (DATA_W'(1) << ST_CLK_EN) : '0;
  localparam logic [NUM_WIN-1:0] WIN_IS_V =
    (NUM_WIN'(1) << WIN_VBLANK) | (NUM_WIN'(1) << WIN_VSYNC) | (NUM_WIN'(1) << WIN_VINT);

  logic [NUM_REGS-1:0][DATA_W-1:0] regQ;
  logic [NUM_WIN-1:0][DATA_W-1:0]  winStart;
  logic [NUM_WIN-1:0][DATA_W-1:0]  winEnd;
  logic [DATA_W-1:0]               hCount;
  logic [DATA_W-1:0]               vCount;
  logic [DATA_W-1:0]               statusWord;
  cnt_strobe_t                     strobe;

  rsg_regfile #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .NUM_REGS   (NUM_REGS),
    .STATUS_RST (STATUS_RST)
  ) i_regs (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .regQ   (regQ)
  );

  assign statusWord = regQ[IDX_STATUS];

  always_comb begin
    winStart[WIN_HBLANK] = '0;
    winEnd[WIN_HBLANK]   = regQ[IDX_H_BLANK];
    winStart[WIN_HSYNC]  = regQ[IDX_H_FP];
    winEnd[WIN_HSYNC]    = regQ[IDX_H_SYNCEND];
    winStart[WIN_VBLANK] = '0;
    winEnd[WIN_VBLANK]   = regQ[IDX_V_BLANK];
    winStart[WIN_VSYNC]  = regQ[IDX_V_FP];
    winEnd[WIN_VSYNC]    = regQ[IDX_V_SYNCEND];
    winStart[WIN_VINT]   = regQ[IDX_VINT_ON];
    winEnd[WIN_VINT]     = regQ[IDX_VINT_OFF];
  end

  rsg_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .hCount (hCount),
    .vCount (vCount),
    .hTotal (regQ[IDX_H_TOTAL]),
    .vTotal (regQ[IDX_V_TOTAL]),
    .clkEn  (statusWord[ST_CLK_EN]),
    .strobe (strobe)
  );

  rsg_datapath #(
    .DATA_W   (DATA_W),
    .NUM_WIN  (NUM_WIN),
    .NUM_PINS (NUM_PINS),
    .WIN_IS_V (WIN_IS_V)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .winStart (winStart),
    .winEnd   (winEnd),
    .outSel   (statusWord[ST_SEL_LSB +: 3]),
    .pinPol   (statusWord[ST_POL_LSB +: NUM_PINS]),
    .hCount   (hCount),
    .vCount   (vCount),
    .outPin   (outPin)
  );

endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] hCount,
  input logic [DATA_W-1:0] vCount,
  input logic [DATA_W-1:0] hTotal,
  input logic [DATA_W-1:0] vTotal,
  input logic [DATA_W-1:0] statusWord,
  input logic [3:0]        outPin
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic clkEn;
  logic hAtLast;
  logic vAtLast;

  assign clkEn   = statusWord[10];
  assign hAtLast = (hCount == DATA_W'(hTotal - ONE));
  assign vAtLast = (vCount == DATA_W'(vTotal - ONE));

  // R1: counters are zero after a reset cycle
  a_r1_reset_zero: assert property (@(posedge clk)
    !rstN |=> (hCount == '0 && vCount == '0));

  a_r3_h_step: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !hAtLast) |=> (hCount == DATA_W'($past(hCount) + ONE)));

  a_r3_h_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && hAtLast) |=> (hCount == '0));

  a_r3_v_hold_mid_line: assert property (@(posedge clk) disable iff (!rstN)
    (!(clkEn && hAtLast)) |=> $stable(vCount));

  a_r4_v_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && hAtLast && vAtLast) |=> (vCount == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(hCount) && $stable(vCount)));

  // R11: cursor never asserts, so pin 2 sits at its inactive level
  a_r11_cursor_idle: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[2:0] == 3'b100 || statusWord[2:0] == 3'b110) |-> (outPin[2] == !statusWord[7]));

endmodule

bind raster_sync_gen rsg_checker #(.DATA_W(DATA_W)) i_rsg_checker (
  .clk        (clk),
  .rstN       (rstN),
  .hCount     (hCount),
  .vCount     (vCount),
  .hTotal     (regQ[rsg_pkg::IDX_H_TOTAL]),
  .vTotal     (regQ[rsg_pkg::IDX_V_TOTAL]),
  .statusWord (regQ[rsg_pkg::IDX_STATUS]),
  .outPin     (outPin)
);

// File: tb/test_raster_sync_gen.sv
`timescale 1ns/1ps
module test_raster_sync_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [11:0] wrData = '0;
  logic [3:0]  outPin;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  bit finished = 1'b0;
  string curTag = "R1";

  always #2 clk = ~clk;

  raster_sync_gen i_raster_sync_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .outPin(outPin)
  );

  // reference model, built from the requirements
  logic [11:0] mReg [15];
  logic [11:0] hM, vM;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 15; i++) mReg[i] <= (i == 0) ? 12'h400 : 12'h000;
      hM <= '0;
      vM <= '0;
    end else begin
      if (mReg[0][10]) begin
        if (hM == 12'(mReg[4] - 12'd1)) begin
          hM <= '0;
          if (vM == 12'(mReg[8] - 12'd1)) vM <= '0;
          else vM <= vM + 12'd1;
        end else begin
          hM <= hM + 12'd1;
        end
      end
      if (wrEn && wrAddr < 4'd15) mReg[wrAddr] <= wrData;
    end
  end

  function automatic logic inWin(logic [11:0] c, logic [11:0] s, logic [11:0] e);
    return (c >= s) && (c < e);
  endfunction

  function automatic logic [3:0] expPins();
    logic hb, hs, vb, vs, vi, cb, cs;
    logic [3:0] sig;
    hb = inWin(hM, 12'd0, mReg[3]);
    hs = inWin(hM, mReg[1], mReg[2]);
    vb = inWin(vM, 12'd0, mReg[7]);
    vs = inWin(vM, mReg[5], mReg[6]);
    vi = inWin(vM, mReg[13], mReg[14]);
    cb = hb | vb;
    cs = hs | vs;
    case (mReg[0][2:0])
      3'd0: sig = {~vb, ~hb, cs, cb};
      3'd1: sig = {~vb, hb, cs, vb};
      3'd2: sig = {hs, ~hb, vs, cb};
      3'd4: sig = {vi, 1'b0, cs, cb};
      3'd5: sig = {vi, hb, cs, vb};
      3'd6: sig = {hs, 1'b0, vs, cb};
      default: sig = {hs, hb, vs, vb};
    endcase
    return sig ^ ~mReg[0][8:5];
  endfunction

  // scoreboard: expected items queued per cycle, monitor pops and compares
  typedef struct { logic [3:0] exp; string tag; } item_t;
  item_t sbq[$];

  always @(negedge clk) begin
    #1;
    if (rstN && running) begin
      item_t it;
      sbq.push_back('{exp: expPins(), tag: curTag});
      it = sbq.pop_front();
      checks++;
      if (outPin !== it.exp) begin
        errors++;
        $display("FAIL %s: outPin=%b expected=%b (h=%0d v=%0d)", it.tag, outPin, it.exp, hM, vM);
      end
    end
  end

  task automatic checkNow(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // caller is at a falling edge; write lands on the next rising edge
  task automatic writeReg(int addr, logic [11:0] data);
    wrEn = 1'b1;
    wrAddr = 4'(addr);
    wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [11:0] mkStatus(logic [2:0] sel, logic [3:0] pol, logic [3:0] extra);
    // extra: {bit11, bit9, bit4, bit3}
    return {extra[3], 1'b1, extra[2], pol, extra[1:0], sel};
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [3:0] held;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1: default pins with clock on and all counts zero
    checkNow("R1 reset pins", outPin, 4'b0011);
    running = 1'b1;
    curTag = "R1 reset";
    idle(4);

    // program a 20 clock line and a 10 line frame
    curTag = "R2 programming";
    writeReg(4, 12'd20);
    writeReg(3, 12'd16);
    writeReg(1, 12'd12);
    writeReg(2, 12'd15);
    writeReg(8, 12'd10);
    writeReg(7, 12'd3);
    writeReg(5, 12'd1);
    writeReg(6, 12'd2);
    writeReg(13, 12'd4);
    writeReg(14, 12'd6);

    // every output set, full frame each
    for (int s = 0; s < 8; s++) begin
      curTag = "R5 R6 R7 R8 R11 select";
      writeReg(0, mkStatus(3'(s), 4'b0000, 4'b0000));
      idle(210);
    end

    // level per pin
    for (int p = 0; p < 4; p++) begin
      logic [3:0] pol;
      pol = (p == 0) ? 4'b1111 : (p == 1) ? 4'b0101 : (p == 2) ? 4'b1010 : 4'b0011;
      curTag = "R9 polarity";
      writeReg(0, mkStatus(3'd4, pol, 4'b0000));
      idle(100);
      writeReg(0, mkStatus(3'd2, pol, 4'b0000));
      idle(100);
    end

    // ignored fields and registers
    curTag = "R12 ignored";
    writeReg(0, mkStatus(3'd3, 4'b1100, 4'b1111));
    writeReg(9, 12'hABC);
    writeReg(10, 12'h005);
    writeReg(11, 12'h001);
    writeReg(12, 12'hFFF);
    idle(210);

    // hold: counting bit cleared
    curTag = "R10 hold";
    writeReg(0, 12'h00B);
    #1;
    held = outPin;
    idle(30);
    #1;
    checkNow("R10 pins frozen", outPin, held);
    writeReg(0, mkStatus(3'd3, 4'b0000, 4'b0000));
    idle(50);

    // write of line length on the wrap edge
    curTag = "R2 R3 write at wrap";
    while (hM != 12'd19) @(negedge clk);
    writeReg(4, 12'd25);
    idle(260);

    // counting bit cleared on a wrap edge
    curTag = "R10 stop at wrap";
    while (hM != 12'd24) @(negedge clk);
    writeReg(0, mkStatus(3'd3, 4'b0000, 4'b0000) & ~12'h400);
    idle(20);
    writeReg(0, mkStatus(3'd3, 4'b0000, 4'b0000));

    // short frame, vertical wrap seen often
    curTag = "R3 R4 short frame";
    writeReg(8, 12'd4);
    writeReg(4, 12'd1);
    idle(30);
    writeReg(4, 12'd6);
    idle(60);

    running = 1'b0;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule